// File: doc/BRIEF.md
# Countdown Interval Timer

This block is a 32-bit down-counting interval timer. It sits behind a small word-addressed register port with separate read and write strobes. Software loads a period, starts or stops the count with command bits in the control register, and picks a single-run or auto-reload mode. A level interrupt tells the processor that the count has run out.

While running, the counter drops by one on every clock. It runs out on the cycle in which it holds 1 or 0. At that point a sticky timeout flag is raised. In auto-reload mode the counter is refilled from the period register and carries on. In single-run mode it parks at zero and stops. Software can read the live count at any time. It acknowledges a timeout by writing anything to the status register.

All accesses are full 32-bit words. Read data is registered and appears on the clock after the read strobe. The interrupt output is also registered.

Top module: `countdown_timer`

## Requirements
- R1: Word address 0 selects status, 1 control, 2 period and 3 snapshot. A read strobe returns the addressed register on `bus_rdata` from the next clock edge onward, and `bus_rdata` holds its value until the next read.
- R2: Status bit 0 is the timeout flag and status bit 1 is the running indicator. All other status bits read 0. The running bit follows the counter and cannot be written.
- R3: Control bit 0 is interrupt enable and bit 1 is auto-reload mode; both are stored and read back. Bit 2 (start) and bit 3 (stop) are commands that are not stored and always read 0. When one write sets both start and stop, the counter ends up stopped.
- R4: Any write to the status register clears the timeout flag, whatever the data. An expiry in the same cycle wins over the clear.
- R5: A write to the period register stores the value and loads it into the counter on the same edge, even while the counter is running. No decrement happens on that edge.
- R6: `irq` is high exactly when the timeout flag and the interrupt enable are both set, and it follows every register write and every expiry.
- R7: While running, the count drops by one per clock. On an edge where the count is 1, the timeout flag is set; in single-run mode the counter stops at 0.
- R8: In auto-reload mode, expiry reloads the counter from the period register and the counter keeps running.
- R9: A snapshot read returns the count as it stood at the clock edge that samples the read. Writes to the snapshot address change nothing.
- R10: Synchronous reset clears status, control, period, count, `bus_rdata` and `irq` to zero, and the counter is stopped.
- R11: A period of zero expires on the first running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per word write |
| bus_rd | input | 1 | Read strobe, one cycle per word read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt, registered |

## Verification
The bench walks through the count one cycle at a time. It reads the snapshot on back-to-back cycles, so a counter that is off by one cycle, or that checks for expiry one step late, shows a wrong value. It reloads the period while the counter is running and then reads both registers; a design that keeps decrementing on the load edge, or ignores the load, reports the wrong count. It sets start and stop in one write and writes junk data to the status and snapshot addresses. A wrong command priority leaves the timer running, and a write that is decoded as storing data shows up in the running bit, the flag or the count. A zero period and a reset in the middle of an auto-reload run round it off. A design that waits for the count to wrap, or that leaves the interrupt or the count standing after reset, fails there.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_SNAP   = 2'd3
  } reg_sel_e;

  // status field positions
  localparam int ST_FLAG = 0;
  localparam int ST_RUN  = 1;
  // control field positions
  localparam int CT_IE    = 0;
  localparam int CT_CONT  = 1;
  localparam int CT_START = 2;
  localparam int CT_STOP  = 3;
endpackage

// File: rtl/ctmr_regfile.sv
module ctmr_regfile
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic              ie,
  output logic              cont,
  output logic [DATA_W-1:0] period,
  output logic              start_cmd,
  output logic              stop_cmd,
  output logic              load,
  output logic              flag,
  output logic              irq
);
  logic wr_status, wr_ctrl;
  logic flag_d, ie_d;

  assign wr_status = wr_en && (addr == SEL_STATUS);
  assign wr_ctrl   = wr_en && (addr == SEL_CTRL);
  assign load      = wr_en && (addr == SEL_PERIOD);
  assign start_cmd = wr_ctrl && wdata[CT_START];
  assign stop_cmd  = wr_ctrl && wdata[CT_STOP];

  // expiry wins over an acknowledge in the same cycle
  always_comb begin
    flag_d = flag;
    if (wr_status) flag_d = 1'b0;
    if (expire)    flag_d = 1'b1;
    ie_d = wr_ctrl ? wdata[CT_IE] : ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie     <= 1'b0;
      cont   <= 1'b0;
      period <= '0;
      flag   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ie   <= wdata[CT_IE];
        cont <= wdata[CT_CONT];
      end
      if (load) period <= wdata;
      flag <= flag_d;
      irq  <= flag_d && ie_d;
    end
  end

  // R4: an acknowledge without a simultaneous expiry leaves the flag clear
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_status && !expire) |=> !flag);

  // R4: an expiry always leaves the flag set
  a_r4_expire_sets: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag);
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              cont,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count,
  output logic              running,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic at_end;

  assign at_end = (count <= ONE);
  assign expire = running && !load && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= '0;
      running <= 1'b0;
    end else begin
      if (load)
        count <= load_val;
      else if (running)
        count <= at_end ? (cont ? period : '0) : (count - ONE);

      if (stop_cmd)
        running <= 1'b0;
      else if (start_cmd)
        running <= 1'b1;
      else if (expire && !cont)
        running <= 1'b0;
    end
  end

  // R7: one step down per running cycle above the end point
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (running && !load && !at_end) |=> (count == $past(count) - ONE));

  // R8: auto-reload refills from period
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (expire && cont) |=> (count == $past(period)));

  // R5: a period write lands in the counter on the same edge
  a_r5_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (count == $past(load_val)));

  // R3: stop wins over start
  a_r3_stop_wins: assert property (@(posedge clk) disable iff (rst)
    stop_cmd |=> !running);
endmodule

// File: rtl/ctmr_rdport.sv
module ctmr_rdport
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              flag,
  input  logic              running,
  input  logic              ie,
  input  logic              cont,
  input  logic [DATA_W-1:0] period,
  input  logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    unique case (reg_sel_e'(addr))
      SEL_STATUS: begin
        sel[ST_FLAG] = flag;
        sel[ST_RUN]  = running;
      end
      SEL_CTRL: begin
        sel[CT_IE]   = ie;
        sel[CT_CONT] = cont;
      end
      SEL_PERIOD: sel = period;
      SEL_SNAP:   sel = count;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

  // R1: data holds between reads
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import ctmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              ie, cont, start_cmd, stop_cmd, load, flag, expire, running;
  logic [DATA_W-1:0] period, count;

  ctmr_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .expire(expire), .ie(ie), .cont(cont), .period(period),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd), .load(load),
    .flag(flag), .irq(irq)
  );

  ctmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .load(load), .load_val(bus_wdata), .cont(cont), .period(period),
    .count(count), .running(running), .expire(expire)
  );

  ctmr_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(bus_rd), .addr(bus_addr),
    .flag(flag), .running(running), .ie(ie), .cont(cont),
    .period(period), .count(count), .rdata(bus_rdata)
  );

  // R6: interrupt level tracks flag and enable
  a_r6_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ie));

  // R11: a zero count while running expires at once
  a_r11_zero_expires: assert property (@(posedge clk) disable iff (rst)
    (running && !load && count == '0) |=> flag);
endmodule

// File: tb/tb_countdown_timer.sv
module tb_countdown_timer;
  localparam int W = 32;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_Q = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 50;
  localparam vec_t VEC [NV] = '{
    '{OP_W, 2'd2, 32'd5,  32'd0,   8'd5},  // R5 period 5
    '{OP_W, 2'd1, 32'h4,  32'd0,   8'd7},  // R7 start one-shot
    '{OP_R, 2'd3, 32'd0,  32'd5,   8'd9},  // R9 live snapshot
    '{OP_R, 2'd3, 32'd0,  32'd4,   8'd7},  // R7 one step
    '{OP_R, 2'd0, 32'd0,  32'h2,   8'd2},  // R2 running, no flag
    '{OP_I, 2'd0, 32'd5,  32'd0,   8'd7},
    '{OP_R, 2'd0, 32'd0,  32'h1,   8'd7},  // R7 flag set, stopped
    '{OP_R, 2'd3, 32'd0,  32'd0,   8'd7},  // R7 parked at zero
    '{OP_R, 2'd1, 32'd0,  32'd0,   8'd3},  // R3 start not stored
    '{OP_Q, 2'd0, 32'd0,  32'd0,   8'd6},  // R6 enable off
    '{OP_W, 2'd0, 32'd0,  32'd0,   8'd4},  // R4 ack
    '{OP_R, 2'd0, 32'd0,  32'd0,   8'd4},
    '{OP_W, 2'd2, 32'd3,  32'd0,   8'd5},
    '{OP_W, 2'd1, 32'h7,  32'd0,   8'd8},  // R8 ie+cont+start
    '{OP_R, 2'd3, 32'd0,  32'd3,   8'd8},
    '{OP_R, 2'd3, 32'd0,  32'd2,   8'd8},
    '{OP_R, 2'd3, 32'd0,  32'd1,   8'd8},
    '{OP_R, 2'd3, 32'd0,  32'd3,   8'd8},  // R8 reloaded
    '{OP_R, 2'd0, 32'd0,  32'h3,   8'd8},  // R8 still running
    '{OP_Q, 2'd0, 32'd0,  32'd1,   8'd6},  // R6
    '{OP_W, 2'd1, 32'hB,  32'd0,   8'd3},  // R3 stop
    '{OP_I, 2'd0, 32'd3,  32'd0,   8'd3},
    '{OP_R, 2'd0, 32'd0,  32'h1,   8'd3},
    '{OP_R, 2'd3, 32'd0,  32'd3,   8'd8},
    '{OP_Q, 2'd0, 32'd0,  32'd1,   8'd6},
    '{OP_W, 2'd0, 32'hFFFFFFFF, 32'd0, 8'd4}, // R4 any data clears
    '{OP_Q, 2'd0, 32'd0,  32'd0,   8'd6},
    '{OP_R, 2'd0, 32'd0,  32'd0,   8'd4},  // R4/R2 run not writable
    '{OP_R, 2'd1, 32'd0,  32'h3,   8'd3},  // R3 commands read 0
    '{OP_W, 2'd1, 32'hC,  32'd0,   8'd3},  // R3 start+stop
    '{OP_I, 2'd0, 32'd2,  32'd0,   8'd3},
    '{OP_R, 2'd0, 32'd0,  32'd0,   8'd3},
    '{OP_R, 2'd3, 32'd0,  32'd3,   8'd3},
    '{OP_Q, 2'd0, 32'd0,  32'd0,   8'd6},
    '{OP_W, 2'd3, 32'h1234, 32'd0, 8'd9},  // R9 write ignored
    '{OP_R, 2'd3, 32'd0,  32'd3,   8'd9},
    '{OP_W, 2'd2, 32'd100, 32'd0,  8'd5},
    '{OP_W, 2'd1, 32'h4,  32'd0,   8'd5},
    '{OP_R, 2'd3, 32'd0,  32'd100, 8'd5},
    '{OP_W, 2'd2, 32'd10, 32'd0,   8'd5},  // R5 load while running
    '{OP_R, 2'd3, 32'd0,  32'd10,  8'd5},
    '{OP_R, 2'd2, 32'd0,  32'd10,  8'd1},  // R1 period readback
    '{OP_W, 2'd1, 32'h8,  32'd0,   8'd5},
    '{OP_R, 2'd3, 32'd0,  32'd7,   8'd5},
    '{OP_W, 2'd2, 32'd0,  32'd0,   8'd11}, // R11 zero period
    '{OP_W, 2'd1, 32'h5,  32'd0,   8'd11},
    '{OP_I, 2'd0, 32'd1,  32'd0,   8'd11},
    '{OP_R, 2'd0, 32'd0,  32'h1,   8'd11},
    '{OP_Q, 2'd0, 32'd0,  32'd1,   8'd6},
    '{OP_R, 2'd3, 32'd0,  32'd0,   8'd11}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic          irq;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  countdown_timer #(.DATA_W(W)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input int req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input int req, input logic [W-1:0] exp);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    check(10, {31'd0, irq}, 32'd0);
    rd(2'd0, 10, 32'd0);
    rd(2'd1, 10, 32'd0);
    rd(2'd2, 10, 32'd0);
    rd(2'd3, 10, 32'd0);

    for (int i = 0; i < NV; i++) begin
      unique case (VEC[i].op)
        OP_W: wr(VEC[i].addr, VEC[i].data);
        OP_R: rd(VEC[i].addr, int'(VEC[i].req), VEC[i].exp);
        OP_I: repeat (int'(VEC[i].data)) @(negedge clk);
        default: check(int'(VEC[i].req), {31'd0, irq}, VEC[i].exp);
      endcase
    end

    // R10: reset in the middle of an auto-reload run
    wr(2'd2, 32'd50);
    wr(2'd1, 32'h7);
    repeat (60) @(negedge clk);
    check(6, {31'd0, irq}, 32'd1);   // R6 raised after expiry
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(10, {31'd0, irq}, 32'd0);
    check(10, bus_rdata, 32'd0);
    rd(2'd0, 10, 32'd0);
    rd(2'd1, 10, 32'd0);
    rd(2'd2, 10, 32'd0);
    repeat (3) @(negedge clk);
    rd(2'd3, 10, 32'd0);             // R10 counter stays stopped

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule